// File: doc/BRIEF.md
# Two-Pin Scan Packet Deserializer

This block sits on the target side of a two-wire debug link. A link clock and one bidirectional data/control pin carry what would otherwise be four TAP wires. The host serializes every TAP clock into a short packet of bit slots. The block collects those slots and presents TMS and TDI to an internal TAP, together with a one-link-clock enable that tells the TAP to take a step. When the slot reserved for the return bit arrives, the block turns the pin around and drives the TAP's TDO back toward the host.

Two packet formats are supported. In the full format, every TAP step costs three link clocks: first the complemented TDI, then TMS, then the returned TDO. In the compact format, packets in Shift-DR or Shift-IR are cut down to a single slot carrying only the complemented TDI. In that case TMS is held low, so the TAP keeps shifting. The host leaves the shift state by raising a separate exit qualifier together with the data slot. That step becomes a TMS=1 step, and full packets resume in the Exit1 state that follows.

The block keeps its own copy of the TAP state. It needs this copy to know the length of the next packet, and it brings the copy out on a port.

Top module: `tp_scan_deser`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `tap_state` reads Test-Logic-Reset (4'hF), `dio_oe` and `tap_tck_en` are 0, and the next link clock is the first slot of a packet.
- R2: A full packet occupies three consecutive link clocks. `tap_tck_en` is 1 only during the third of them, and it is 0 in the first two.
- R3: The pin value in the first slot is the complement of TDI. During the step cycle, `tap_tdi` shows that value inverted back.
- R4: The pin value in the second slot of a full packet is TMS and appears on `tap_tms` in the step cycle. `tap_state` changes only at the end of a step cycle, and it follows the standard 16-state TAP graph with this encoding: TLR=F, RTI=C, SelDR=7, CapDR=6, ShDR=2, Ex1DR=1, PauseDR=3, Ex2DR=0, UpdDR=5, SelIR=4, CapIR=E, ShIR=A, Ex1IR=9, PauseIR=B, Ex2IR=8, UpdIR=D.
- R5: `dio_oe` is 1 only during the third slot of a full packet. In that slot `dio_out` equals `tap_tdo`, and `dio_oe` never stays high for two cycles in a row.
- R6: With `compact_mode` at 1 and `tap_state` in ShDR or ShIR, every link clock is a one-slot packet. `tap_tck_en` is 1 in each such cycle, `tap_tdi` is the inverted pin value, and `dio_oe` stays 0.
- R7: In a one-slot packet, `tap_tms` equals `link_exit`. A packet with `link_exit` at 1 moves the TAP to the Exit1 state of the same path, and the packets after it have three slots again.
- R8: With `compact_mode` at 1 and the TAP outside the two shift states, packets keep the full three-slot form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| compact_mode | input | 1 | 1 selects one-slot packets during shift states |
| link_exit | input | 1 | Exit qualifier sampled with a one-slot packet |
| dio_in | input | 1 | Data/control pin, input side |
| dio_out | output | 1 | Data/control pin, output value |
| dio_oe | output | 1 | Data/control pin driver enable |
| tap_tdo | input | 1 | TDO from the internal TAP |
| tap_tck_en | output | 1 | TAP step enable, one link clock wide |
| tap_tms | output | 1 | Recovered TMS, valid with tap_tck_en |
| tap_tdi | output | 1 | Recovered TDI, valid with tap_tck_en |
| tap_state | output | 4 | Tracked TAP state (encoding in R4) |

## Verification
A long pseudo-random walk of full packets covers the TAP graph and all combinations of TDI, TMS and TDO. The bench compares every step with its own state table. A design that forgot to invert TDI, swapped the first two slots or stepped in the wrong slot would show wrong `tap_tdi`, `tap_tms` or `tap_state` values on the first few packets. The compact-format runs go into both shift states and leave them through the exit qualifier. A design that kept three-slot packets in shift, or that did not return to three slots after the exit, would assert `tap_tck_en` in the wrong cycles. A design that drove the pin in a one-slot packet would show `dio_oe` high where it must be 0.

// File: rtl/tp_pkg.sv
package tp_pkg;

  localparam int FULL_SLOTS = 3;
  localparam int SLOT_W     = $clog2(FULL_SLOTS);
  localparam int SLOT_NTDI  = 0;
  localparam int SLOT_TMS   = 1;
  localparam int SLOT_TDO   = FULL_SLOTS - 1;

  typedef enum logic [3:0] {
    ST_EX2DR = 4'h0, ST_EX1DR = 4'h1, ST_SHDR  = 4'h2, ST_PSDR  = 4'h3,
    ST_SELIR = 4'h4, ST_UPDR  = 4'h5, ST_CAPDR = 4'h6, ST_SELDR = 4'h7,
    ST_EX2IR = 4'h8, ST_EX1IR = 4'h9, ST_SHIR  = 4'hA, ST_PSIR  = 4'hB,
    ST_RTI   = 4'hC, ST_UPIR  = 4'hD, ST_CAPIR = 4'hE, ST_TLR   = 4'hF
  } tap_st_t;

  function automatic tap_st_t tap_next(input tap_st_t s, input logic tms);
    case (s)
      ST_TLR:   return tms ? ST_TLR   : ST_RTI;
      ST_RTI:   return tms ? ST_SELDR : ST_RTI;
      ST_SELDR: return tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: return tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  return tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: return tms ? ST_UPDR  : ST_PSDR;
      ST_PSDR:  return tms ? ST_EX2DR : ST_PSDR;
      ST_EX2DR: return tms ? ST_UPDR  : ST_SHDR;
      ST_UPDR:  return tms ? ST_SELDR : ST_RTI;
      ST_SELIR: return tms ? ST_TLR   : ST_CAPIR;
      ST_CAPIR: return tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  return tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: return tms ? ST_UPIR  : ST_PSIR;
      ST_PSIR:  return tms ? ST_EX2IR : ST_PSIR;
      ST_EX2IR: return tms ? ST_UPIR  : ST_SHIR;
      default:  return tms ? ST_SELDR : ST_RTI;
    endcase
  endfunction

  function automatic logic is_shift(input tap_st_t s);
    return (s == ST_SHDR) || (s == ST_SHIR);
  endfunction

  // Number of slots in the packet that starts while the TAP is in state s.
  function automatic int unsigned pkt_len(input logic compact, input tap_st_t s);
    return (compact && is_shift(s)) ? 1 : FULL_SLOTS;
  endfunction

endpackage

// File: rtl/tp_slot_ctr.sv
module tp_slot_ctr #(
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  output logic [SLOT_W-1:0] slot
);
  always_ff @(posedge clk) begin
    if (!rst_n)    slot <= '0;
    else if (last) slot <= '0;
    else           slot <= slot + 1'b1;
  end
endmodule

// File: rtl/tp_slot_capture.sv
module tp_slot_capture #(
  parameter int SLOT_W = 2,
  parameter int TDI_SLOT = 0,
  parameter int TMS_SLOT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic              short_pkt,
  input  logic              dio_in,
  input  logic              link_exit,
  output logic              tdi,
  output logic              tms
);
  logic tdi_q, tms_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdi_q <= 1'b0;
      tms_q <= 1'b1;
    end else begin
      if (slot == SLOT_W'(TDI_SLOT)) tdi_q <= ~dio_in;
      if (slot == SLOT_W'(TMS_SLOT)) tms_q <= dio_in;
    end
  end

  // One-slot packets present their bit in the same cycle they arrive.
  assign tdi = short_pkt ? ~dio_in   : tdi_q;
  assign tms = short_pkt ? link_exit : tms_q;
endmodule

// File: rtl/tp_tap_fsm.sv
module tp_tap_fsm
  import tp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    step,
  input  logic    tms,
  output tap_st_t state
);
  always_ff @(posedge clk) begin
    if (!rst_n)    state <= ST_TLR;
    else if (step) state <= tap_next(state, tms);
  end

  p_step_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state) |-> $past(step));
endmodule

// File: rtl/tp_scan_deser.sv
module tp_scan_deser
  import tp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       compact_mode,
  input  logic       link_exit,
  input  logic       dio_in,
  output logic       dio_out,
  output logic       dio_oe,
  input  logic       tap_tdo,
  output logic       tap_tck_en,
  output logic       tap_tms,
  output logic       tap_tdi,
  output logic [3:0] tap_state
);
  logic [SLOT_W-1:0] slot_idx;
  tap_st_t           cur_st;
  logic              short_pkt;
  logic              pkt_done;
  logic              rec_tms, rec_tdi;
  int unsigned       cur_len;

  assign cur_len   = pkt_len(compact_mode, cur_st);
  assign short_pkt = (cur_len == 1) && (slot_idx == '0);
  assign pkt_done  = (32'(slot_idx) >= cur_len - 1);

  tp_slot_ctr #(.SLOT_W(SLOT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .last(pkt_done), .slot(slot_idx));

  tp_slot_capture #(.SLOT_W(SLOT_W), .TDI_SLOT(SLOT_NTDI), .TMS_SLOT(SLOT_TMS)) u_cap (
    .clk(clk), .rst_n(rst_n), .slot(slot_idx), .short_pkt(short_pkt),
    .dio_in(dio_in), .link_exit(link_exit), .tdi(rec_tdi), .tms(rec_tms));

  tp_tap_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .step(pkt_done), .tms(rec_tms), .state(cur_st));

  assign tap_tck_en = rst_n && pkt_done;
  assign tap_tms    = rec_tms;
  assign tap_tdi    = rec_tdi;
  assign tap_state  = cur_st;
  assign dio_oe     = rst_n && !short_pkt && (slot_idx == SLOT_W'(SLOT_TDO));
  assign dio_out    = dio_oe ? tap_tdo : 1'b0;

  p_oe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dio_oe |=> !dio_oe);

  p_short_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (compact_mode && $past(compact_mode) && is_shift(cur_st) && $past(pkt_done))
      |-> (pkt_done && !dio_oe));

  p_full_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !compact_mode && !$past(compact_mode) && !$past(compact_mode, 2))
      |-> (!$past(pkt_done) && !$past(pkt_done, 2)));

  p_oe_with_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dio_oe |-> tap_tck_en);
endmodule

// File: tb/tp_scan_deser_tb.sv
module tp_scan_deser_tb;
  logic clk = 1'b0;
  logic rst_n, compact_mode, link_exit, dio_in, tap_tdo;
  logic dio_out, dio_oe, tap_tck_en, tap_tms, tap_tdi;
  logic [3:0] tap_state;
  int checks = 0, errors = 0;
  logic [3:0] mst;
  logic [7:0] lfsr;
  bit done = 0;

  always #2.5 clk = ~clk;

  tp_scan_deser u_dut (
    .clk(clk), .rst_n(rst_n), .compact_mode(compact_mode), .link_exit(link_exit),
    .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe), .tap_tdo(tap_tdo),
    .tap_tck_en(tap_tck_en), .tap_tms(tap_tms), .tap_tdi(tap_tdi), .tap_state(tap_state));

  function automatic logic [3:0] ref_next(input logic [3:0] s, input logic m);
    logic [3:0] a, b;
    case (s)
      4'hF: begin a = 4'hC; b = 4'hF; end
      4'hC: begin a = 4'hC; b = 4'h7; end
      4'h7: begin a = 4'h6; b = 4'h4; end
      4'h6: begin a = 4'h2; b = 4'h1; end
      4'h2: begin a = 4'h2; b = 4'h1; end
      4'h1: begin a = 4'h3; b = 4'h5; end
      4'h3: begin a = 4'h3; b = 4'h0; end
      4'h0: begin a = 4'h2; b = 4'h5; end
      4'h5: begin a = 4'hC; b = 4'h7; end
      4'h4: begin a = 4'hE; b = 4'hF; end
      4'hE: begin a = 4'hA; b = 4'h9; end
      4'hA: begin a = 4'hA; b = 4'h9; end
      4'h9: begin a = 4'hB; b = 4'hD; end
      4'hB: begin a = 4'hB; b = 4'h8; end
      4'h8: begin a = 4'hA; b = 4'hD; end
      default: begin a = 4'hC; b = 4'h7; end
    endcase
    return m ? b : a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entered just after a posedge; leaves just after the posedge that ends the packet.
  task automatic send_full(input logic tdi, input logic tms, input logic tdo);
    dio_in = ~tdi; link_exit = 1'b0;
    @(negedge clk);
    chk(tap_tck_en == 1'b0, "R2 slot1 no step", tap_tck_en, 0);
    chk(dio_oe == 1'b0, "R5 slot1 released", dio_oe, 0);
    @(posedge clk); #1;
    dio_in = tms;
    @(negedge clk);
    chk(tap_tck_en == 1'b0, "R2 slot2 no step", tap_tck_en, 0);
    chk(dio_oe == 1'b0, "R5 slot2 released", dio_oe, 0);
    @(posedge clk); #1;
    dio_in = 1'b0; tap_tdo = tdo;
    @(negedge clk);
    chk(tap_tck_en == 1'b1, "R2 slot3 step", tap_tck_en, 1);
    chk(dio_oe == 1'b1, "R5 slot3 driven", dio_oe, 1);
    chk(dio_out == tdo, "R5 tdo value", dio_out, tdo);
    chk(tap_tdi == tdi, "R3 tdi restored", tap_tdi, tdi);
    chk(tap_tms == tms, "R4 tms value", tap_tms, tms);
    @(posedge clk); #1;
    mst = ref_next(mst, tms);
    chk(tap_state == mst, "R4 state", tap_state, mst);
  endtask

  task automatic send_short(input logic tdi, input logic ex);
    dio_in = ~tdi; link_exit = ex;
    @(negedge clk);
    chk(tap_tck_en == 1'b1, "R6 one-slot step", tap_tck_en, 1);
    chk(dio_oe == 1'b0, "R6 pin released", dio_oe, 0);
    chk(tap_tdi == tdi, "R6 tdi restored", tap_tdi, tdi);
    chk(tap_tms == ex, "R7 tms from exit", tap_tms, ex);
    @(posedge clk); #1;
    link_exit = 1'b0;
    mst = ref_next(mst, ex);
    chk(tap_state == mst, "R7 state", tap_state, mst);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; compact_mode = 1'b0; link_exit = 1'b0; dio_in = 1'b1; tap_tdo = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tap_state == 4'hF, "R1 reset state", tap_state, 15);
    chk(dio_oe == 1'b0, "R1 reset oe", dio_oe, 0);
    chk(tap_tck_en == 1'b0, "R1 reset step", tap_tck_en, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    mst = 4'hF;
    @(negedge clk);
    chk(tap_state == 4'hF, "R1 after release", tap_state, 15);
    @(posedge clk); #1;
    // The previous cycle was slot 1; finish that packet with TMS=1 (stays TLR).
    dio_in = 1'b1;
    @(posedge clk); #1;
    tap_tdo = 1'b0;
    @(negedge clk);
    chk(tap_tck_en == 1'b1, "R1 first packet aligned", tap_tck_en, 1);
    @(posedge clk); #1;

    // Exhaustive combinations of the three slots.
    for (int v = 0; v < 8; v++) send_full(v[0], v[1], v[2]);

    // Pseudo-random walk over the TAP graph, full format.
    lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send_full(lfsr[0], lfsr[3] & lfsr[6], lfsr[2]);
    end

    // Compact format: go to TLR, then into Shift-DR.
    for (int i = 0; i < 5; i++) send_full(1'b0, 1'b1, 1'b0);
    compact_mode = 1'b1;
    send_full(1'b1, 1'b0, 1'b1); // RTI (R8 full while not shifting)
    send_full(1'b0, 1'b1, 1'b0); // SelDR
    send_full(1'b1, 1'b0, 1'b1); // CapDR
    send_full(1'b0, 1'b0, 1'b0); // ShDR
    for (int i = 0; i < 10; i++) send_short(i[0] ^ i[2], 1'b0);
    send_short(1'b1, 1'b1);      // exit to Ex1DR
    chk(tap_state == 4'h1, "R7 exit1 dr", tap_state, 1);
    send_full(1'b0, 1'b1, 1'b1); // UpdDR, R7 full again
    send_full(1'b0, 1'b1, 1'b0); // SelDR
    send_full(1'b0, 1'b1, 1'b1); // SelIR
    send_full(1'b1, 1'b0, 1'b0); // CapIR
    send_full(1'b0, 1'b0, 1'b1); // ShIR
    for (int i = 0; i < 6; i++) send_short(~i[1], 1'b0);
    send_short(1'b0, 1'b1);      // Ex1IR
    chk(tap_state == 4'h9, "R7 exit1 ir", tap_state, 9);
    send_full(1'b1, 1'b0, 1'b1); // PauseIR, R8
    send_full(1'b0, 1'b1, 1'b0); // Ex2IR
    send_full(1'b0, 1'b0, 1'b1); // back to ShIR
    send_short(1'b1, 1'b0);
    send_short(1'b0, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule